// File: doc/BRIEF.md
# Two-Master Shared Open-Drain Line Arbiter

This block lets two bus masters take turns on one shared open-drain data line, the single-wire kind on which one controller at a time runs reset, presence and bit slots. Each master talks to the arbiter over its own command port. A command byte holds the sender's identity in the upper nibble and an operation code in the lower nibble. A request asks for the line and a release gives it back. The arbiter keeps one ownership register and answers each grant with a one-cycle strobe that carries a grant byte addressed to the winner. A master only touches the line once it has seen its own grant byte.

Only the owner's pull-low request reaches the line output-enable. The other master's path stays released. The block never drives the line high. A pull-up outside the block provides the high level.

A hold timer guards against an owner that never lets go. When the owner keeps the line for the configured number of cycles without releasing it, the arbiter takes ownership back, strobes a timeout event and raises a kill output for a configured number of cycles so that the bus can be reset. While kill is high, no command is accepted and no grant is issued. Requests that are still waiting are served after kill ends. Commands that would have no effect are dropped and counted in a saturating error counter.

Top module: `shline_arbiter`

## Requirements
- R1: After reset the owner is 0, `line_oe`, `kill`, `gnt_valid` and `timeout_evt` are low, `err_count` is 0 and both command ports show ready. This holds even while both masters request pull-low.
- R2: A command byte is decoded as identity in bits [7:4] and opcode in bits [3:0]. Port A must carry identity 1 and port B identity 2. Opcode 1 is a request and opcode 3 is a release. A byte with a wrong identity or any other opcode is dropped and counted.
- R3: The owner code is 0 for none, 1 for master A and 2 for master B. A request accepted while the line is free sets the owner on that same clock edge. On that edge `gnt_valid` goes high for one cycle, and `gnt_data` carries the winner's identity in bits [7:4] and opcode 2 in bits [3:0] (0x12 for A, 0x22 for B).
- R4: A request from the non-owner waits as pending. It is granted on the edge that accepts the owner's release, or on a later edge when the line is free.
- R5: When both masters want a free line on the same edge, the master that did not hold the line most recently wins. The first such tie after reset goes to A. The loser stays pending.
- R6: `line_oe` is high only when the owner's own pull-low input is high. The non-owner's pull-low input never reaches the line, and neither input does while there is no owner.
- R7: Three commands are ignored and leave ownership and pending state unchanged: a release from a master that is not the owner, a request from the owner, and a request from a master that is already pending. Each ignored or malformed command adds 1 to `err_count`, which saturates at its all-ones value.
- R8: An owner that holds the line for `hold_limit` cycles without releasing it is revoked. The owner becomes 0 and `timeout_evt` pulses for one cycle. A release accepted on the expiry edge wins over the timeout. A `hold_limit` of 0 acts as 1.
- R9: `kill` rises together with `timeout_evt` and stays high for exactly `kill_len` cycles. A `kill_len` of 0 acts as 1. Both ready outputs are low while `kill` is high. The first grant comes on the edge after `kill` falls.
- R10: The hold timer starts from zero at every grant, so a master that releases the line and takes it again gets a full `hold_limit` window.
- R11: A command takes effect only on a clock edge where its port's valid and ready are both high. Ready is the only back-pressure: a master must hold valid and its byte steady until it sees ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_cmd_valid | input | 1 | Master A command byte valid |
| a_cmd_ready | output | 1 | Master A command accepted when high with valid |
| a_cmd_data | input | 8 | Master A command byte (identity, opcode) |
| b_cmd_valid | input | 1 | Master B command byte valid |
| b_cmd_ready | output | 1 | Master B command accepted when high with valid |
| b_cmd_data | input | 8 | Master B command byte (identity, opcode) |
| a_drive_low | input | 1 | Master A asks to pull the shared line low |
| b_drive_low | input | 1 | Master B asks to pull the shared line low |
| hold_limit | input | TMR_W | Cycles an owner may keep the line |
| kill_len | input | KILL_W | Length of the kill pulse in cycles |
| line_oe | output | 1 | Open-drain enable: high pulls the shared line low |
| kill | output | 1 | Bus reset pulse after a forced revocation |
| owner | output | 2 | Current owner code (0 none, 1 A, 2 B) |
| gnt_valid | output | 1 | One-cycle strobe with a grant byte |
| gnt_data | output | 8 | Grant byte addressed to the new owner |
| timeout_evt | output | 1 | One-cycle strobe on forced revocation |
| err_count | output | ERR_W | Saturating count of ignored commands |

## Verification
The bench builds the arbiter with a 5-bit hold timer, a 3-bit kill length and a 3-bit error counter. With the 3-bit counter, saturation is reached after seven ignored commands, including an edge where both ports send an ignored command together. With the small timer, a sweep of every hold limit from 1 to 6 against every kill length from 1 to 4 stays short. That sweep measures the owner window, the kill width, ready suppression and the pending grant after kill. It also covers the single-cycle limit, where a release and an expiry land on the same edge. A limit of 31 in the other tests keeps those tests free of timeouts, so grants, tie-breaks and line gating can be checked on their own.

// File: rtl/shline_pkg.sv
package shline_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

  localparam logic [3:0] OP_REQ = 4'h1;
  localparam logic [3:0] OP_GNT = 4'h2;
  localparam logic [3:0] OP_REL = 4'h3;

  localparam logic [3:0] ID_A = 4'h1;
  localparam logic [3:0] ID_B = 4'h2;

  typedef struct packed {
    logic req;
    logic rel;
    logic bad;
  } cmd_t;

endpackage

// File: rtl/shline_cmd_decode.sv
module shline_cmd_decode
  import shline_pkg::*;
#(
  parameter logic [3:0] MY_ID = ID_A
) (
  input  logic       valid,
  input  logic       ready,
  input  logic [7:0] data,
  output cmd_t       cmd
);
  logic       fire;
  logic       id_ok;
  logic [3:0] op;

  assign fire  = valid & ready;
  assign id_ok = (data[7:4] == MY_ID);
  assign op    = data[3:0];

  always_comb begin
    cmd.req = fire & id_ok & (op == OP_REQ);
    cmd.rel = fire & id_ok & (op == OP_REL);
    cmd.bad = fire & ~(id_ok & ((op == OP_REQ) | (op == OP_REL)));
  end
endmodule

// File: rtl/shline_hold_timer.sv
module shline_hold_timer #(
  parameter int TMR_W  = 16,
  parameter int KILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              owner_rel,
  input  logic [TMR_W-1:0]  hold_limit,
  input  logic [KILL_W-1:0] kill_len,
  output logic              revoke,
  output logic              kill_active,
  output logic              timeout_evt
);
  logic [TMR_W-1:0]  tmr_q;
  logic [TMR_W-1:0]  limit_eff;
  logic [KILL_W-1:0] kill_eff;
  logic [KILL_W-1:0] kill_q;
  logic              at_limit;

  assign limit_eff   = (hold_limit == '0) ? TMR_W'(1) : hold_limit;
  assign kill_eff    = (kill_len == '0) ? KILL_W'(1) : kill_len;
  assign at_limit    = (tmr_q >= (limit_eff - TMR_W'(1)));
  assign revoke      = busy & at_limit & ~owner_rel;
  assign kill_active = (kill_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q       <= '0;
      kill_q      <= '0;
      timeout_evt <= 1'b0;
    end else begin
      timeout_evt <= revoke;
      if (!busy || owner_rel || revoke) tmr_q <= '0;
      else                               tmr_q <= tmr_q + TMR_W'(1);
      if (revoke)           kill_q <= kill_eff;
      else if (kill_active) kill_q <= kill_q - KILL_W'(1);
    end
  end
endmodule

// File: rtl/shline_own_ctrl.sv
module shline_own_ctrl
  import shline_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_t       cmd_a,
  input  cmd_t       cmd_b,
  input  logic       revoke,
  input  logic       kill_active,
  output logic [1:0] owner,
  output logic       owner_rel,
  output logic       gnt_valid,
  output logic [7:0] gnt_data,
  output logic       ign_a,
  output logic       ign_b
);
  owner_e owner_q;
  owner_e last_q;
  logic   pend_a_q, pend_b_q;
  logic   own_a, own_b;
  logic   new_a, new_b, want_a, want_b;
  logic   free_now, can_grant, pick_a;

  assign own_a = (owner_q == OWN_A);
  assign own_b = (owner_q == OWN_B);

  assign owner_rel = (own_a & cmd_a.rel) | (own_b & cmd_b.rel);

  assign ign_a = cmd_a.bad | (cmd_a.req & (own_a | pend_a_q)) | (cmd_a.rel & ~own_a);
  assign ign_b = cmd_b.bad | (cmd_b.req & (own_b | pend_b_q)) | (cmd_b.rel & ~own_b);

  assign new_a  = cmd_a.req & ~own_a & ~pend_a_q;
  assign new_b  = cmd_b.req & ~own_b & ~pend_b_q;
  assign want_a = pend_a_q | new_a;
  assign want_b = pend_b_q | new_b;

  assign free_now  = (owner_q == OWN_NONE) | owner_rel;
  assign can_grant = free_now & ~kill_active & (want_a | want_b);
  assign pick_a    = want_a & (~want_b | (last_q == OWN_B));

  assign owner = owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= OWN_NONE;
      last_q    <= OWN_B;
      pend_a_q  <= 1'b0;
      pend_b_q  <= 1'b0;
      gnt_valid <= 1'b0;
      gnt_data  <= 8'h00;
    end else begin
      gnt_valid <= can_grant;
      if (can_grant) gnt_data <= {(pick_a ? ID_A : ID_B), OP_GNT};

      if (revoke)         owner_q <= OWN_NONE;
      else if (can_grant) owner_q <= pick_a ? OWN_A : OWN_B;
      else if (owner_rel) owner_q <= OWN_NONE;

      if (can_grant) last_q <= pick_a ? OWN_A : OWN_B;

      pend_a_q <= want_a & ~(can_grant & pick_a);
      pend_b_q <= want_b & ~(can_grant & ~pick_a);
    end
  end
endmodule

// File: rtl/shline_err_counter.sv
module shline_err_counter #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ign_a,
  input  logic             ign_b,
  output logic [ERR_W-1:0] err_count
);
  logic [ERR_W:0] total;
  logic [1:0]     inc;

  assign inc   = {1'b0, ign_a} + {1'b0, ign_b};
  assign total = {1'b0, err_count} + (ERR_W + 1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)          err_count <= '0;
    else if (total[ERR_W]) err_count <= '1;
    else                 err_count <= total[ERR_W-1:0];
  end
endmodule

// File: rtl/shline_drive_gate.sv
module shline_drive_gate #(
  parameter int N_MST = 2
) (
  input  logic [1:0]       owner,
  input  logic [N_MST-1:0] drive_low,
  output logic             line_oe
);
  logic [N_MST-1:0] pass;

  for (genvar i = 0; i < N_MST; i++) begin : g_path
    assign pass[i] = drive_low[i] & (owner == 2'(i + 1));
  end

  assign line_oe = |pass;
endmodule

// File: rtl/shline_arbiter.sv
module shline_arbiter
  import shline_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int KILL_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cmd_valid,
  output logic              a_cmd_ready,
  input  logic [7:0]        a_cmd_data,
  input  logic              b_cmd_valid,
  output logic              b_cmd_ready,
  input  logic [7:0]        b_cmd_data,
  input  logic              a_drive_low,
  input  logic              b_drive_low,
  input  logic [TMR_W-1:0]  hold_limit,
  input  logic [KILL_W-1:0] kill_len,
  output logic              line_oe,
  output logic              kill,
  output logic [1:0]        owner,
  output logic              gnt_valid,
  output logic [7:0]        gnt_data,
  output logic              timeout_evt,
  output logic [ERR_W-1:0]  err_count
);
  cmd_t cmd_a, cmd_b;
  logic revoke, kill_active, owner_rel, ign_a, ign_b;

  assign a_cmd_ready = ~kill_active;
  assign b_cmd_ready = ~kill_active;
  assign kill        = kill_active;

  shline_cmd_decode #(.MY_ID(ID_A)) dec_a_i (
    .valid(a_cmd_valid), .ready(a_cmd_ready), .data(a_cmd_data), .cmd(cmd_a)
  );

  shline_cmd_decode #(.MY_ID(ID_B)) dec_b_i (
    .valid(b_cmd_valid), .ready(b_cmd_ready), .data(b_cmd_data), .cmd(cmd_b)
  );

  shline_own_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .revoke(revoke), .kill_active(kill_active), .owner(owner),
    .owner_rel(owner_rel), .gnt_valid(gnt_valid), .gnt_data(gnt_data),
    .ign_a(ign_a), .ign_b(ign_b)
  );

  shline_hold_timer #(.TMR_W(TMR_W), .KILL_W(KILL_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .busy(owner != 2'd0), .owner_rel(owner_rel),
    .hold_limit(hold_limit), .kill_len(kill_len), .revoke(revoke),
    .kill_active(kill_active), .timeout_evt(timeout_evt)
  );

  shline_err_counter #(.ERR_W(ERR_W)) err_i (
    .clk(clk), .rst_n(rst_n), .ign_a(ign_a), .ign_b(ign_b), .err_count(err_count)
  );

  shline_drive_gate #(.N_MST(2)) gate_i (
    .owner(owner), .drive_low({b_drive_low, a_drive_low}), .line_oe(line_oe)
  );
endmodule

// File: rtl/shline_arbiter_chk.sv
module shline_arbiter_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_cmd_ready,
  input logic             b_cmd_ready,
  input logic             a_drive_low,
  input logic             b_drive_low,
  input logic             line_oe,
  input logic             kill,
  input logic [1:0]       owner,
  input logic             gnt_valid,
  input logic [7:0]       gnt_data,
  input logic             timeout_evt,
  input logic [ERR_W-1:0] err_count
);
  a_r3_owner_code: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd3);

  a_r3_grant_byte: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_data == {2'b00, owner, 4'h2}));

  a_r3_takeover_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != 2'd0 && owner != $past(owner)) |-> gnt_valid);

  a_r6_gated_drive: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> ((owner == 2'd1 && a_drive_low) || (owner == 2'd2 && b_drive_low)));

  a_r7_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    err_count >= $past(err_count));

  a_r8_timeout_revokes: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> (owner == 2'd0 && kill));

  a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt);

  a_r9_kill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (!gnt_valid && !a_cmd_ready && !b_cmd_ready && owner == 2'd0));
endmodule

bind shline_arbiter shline_arbiter_chk #(.ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .a_cmd_ready(a_cmd_ready), .b_cmd_ready(b_cmd_ready),
  .a_drive_low(a_drive_low), .b_drive_low(b_drive_low), .line_oe(line_oe),
  .kill(kill), .owner(owner), .gnt_valid(gnt_valid), .gnt_data(gnt_data),
  .timeout_evt(timeout_evt), .err_count(err_count)
);

// File: tb/shline_arbiter_tb_top.sv
module shline_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMR_W  = 5;
  localparam int KILL_W = 3;
  localparam int ERR_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_cmd_valid = 1'b0, b_cmd_valid = 1'b0;
  logic a_cmd_ready, b_cmd_ready;
  logic [7:0] a_cmd_data = 8'h00, b_cmd_data = 8'h00;
  logic a_drive_low = 1'b0, b_drive_low = 1'b0;
  logic [TMR_W-1:0]  hold_limit = 5'd31;
  logic [KILL_W-1:0] kill_len = 3'd1;
  logic line_oe, kill, gnt_valid, timeout_evt;
  logic [1:0] owner;
  logic [7:0] gnt_data;
  logic [ERR_W-1:0] err_count;

  int n_chk = 0;
  int n_fail = 0;

  shline_arbiter #(.TMR_W(TMR_W), .KILL_W(KILL_W), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_cmd_valid(a_cmd_valid), .a_cmd_ready(a_cmd_ready), .a_cmd_data(a_cmd_data),
    .b_cmd_valid(b_cmd_valid), .b_cmd_ready(b_cmd_ready), .b_cmd_data(b_cmd_data),
    .a_drive_low(a_drive_low), .b_drive_low(b_drive_low),
    .hold_limit(hold_limit), .kill_len(kill_len),
    .line_oe(line_oe), .kill(kill), .owner(owner), .gnt_valid(gnt_valid),
    .gnt_data(gnt_data), .timeout_evt(timeout_evt), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send2(logic va, logic [7:0] da, logic vb, logic [7:0] db);
    a_cmd_valid = va; a_cmd_data = da;
    b_cmd_valid = vb; b_cmd_data = db;
    step();
    a_cmd_valid = 1'b0; b_cmd_valid = 1'b0;
  endtask

  task automatic send_a(logic [7:0] d);
    send2(1'b1, d, 1'b0, 8'h00);
  endtask

  task automatic send_b(logic [7:0] d);
    send2(1'b0, 8'h00, 1'b1, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    a_cmd_valid = 1'b0; b_cmd_valid = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic gate_sweep(int own);
    for (int d = 0; d < 4; d++) begin
      a_drive_low = d[0];
      b_drive_low = d[1];
      #1;
      chk($sformatf("R6 line_oe owner=%0d drv=%0d", own, d), int'(line_oe),
          int'((own == 1 && d[0]) || (own == 2 && d[1])));
    end
    a_drive_low = 1'b0;
    b_drive_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int exp_err;
    int cnt;
    // R1 reset state, with both masters asking to pull low
    a_drive_low = 1'b1; b_drive_low = 1'b1;
    do_reset();
    chk("R1 owner", int'(owner), 0);
    chk("R1 line_oe", int'(line_oe), 0);
    chk("R1 kill", int'(kill), 0);
    chk("R1 gnt_valid", int'(gnt_valid), 0);
    chk("R1 timeout_evt", int'(timeout_evt), 0);
    chk("R1 err_count", int'(err_count), 0);
    chk("R1 ready", int'({a_cmd_ready, b_cmd_ready}), 3);
    a_drive_low = 1'b0; b_drive_low = 1'b0;

    // R11 byte with valid low has no effect
    a_cmd_data = 8'h11; step(); step();
    chk("R11 no valid no grant", int'(owner), 0);

    // R6 gating for each owner, R3 grants
    gate_sweep(0);
    send_a(8'h11);
    chk("R3 owner A", int'(owner), 1);
    chk("R3 gnt_valid A", int'(gnt_valid), 1);
    chk("R3 gnt byte A", int'(gnt_data), 8'h12);
    gate_sweep(1);
    step();
    chk("R3 strobe one cycle", int'(gnt_valid), 0);
    send_a(8'h13);
    chk("R3 release A", int'(owner), 0);
    send_b(8'h21);
    chk("R3 owner B", int'(owner), 2);
    chk("R3 gnt byte B", int'(gnt_data), 8'h22);
    gate_sweep(2);
    send_b(8'h23);
    chk("R3 release B", int'(owner), 0);

    // R5 tie-breaks, R4 pending handover
    do_reset();
    send2(1'b1, 8'h11, 1'b1, 8'h21);
    chk("R5 first tie to A", int'(owner), 1);
    chk("R5 tie grant byte", int'(gnt_data), 8'h12);
    send_a(8'h13);
    chk("R4 pending B on release", int'(owner), 2);
    chk("R4 pending B strobe", int'(gnt_valid), 1);
    chk("R4 pending B byte", int'(gnt_data), 8'h22);
    send_b(8'h23);
    chk("R4 idle after release", int'(owner), 0);
    send_a(8'h11);
    send_a(8'h13);
    send2(1'b1, 8'h11, 1'b1, 8'h21);
    chk("R5 tie after A goes to B", int'(owner), 2);
    send_b(8'h23);
    chk("R5 loser A served", int'(owner), 1);
    send_a(8'h13);
    chk("R5 idle", int'(owner), 0);

    // R7 ignored commands, R2 malformed bytes
    do_reset();
    exp_err = 0;
    send_b(8'h23); exp_err++;
    chk("R7 release from non-owner", int'(err_count), exp_err);
    chk("R7 release no owner change", int'(owner), 0);
    send_a(8'h11);
    send_a(8'h11); exp_err++;
    chk("R7 request from owner", int'(err_count), exp_err);
    chk("R7 owner request no strobe", int'(gnt_valid), 0);
    send_b(8'h21);
    chk("R4 pending no error", int'(err_count), exp_err);
    send_b(8'h21); exp_err++;
    chk("R7 repeat pending request", int'(err_count), exp_err);
    send_b(8'h23); exp_err++;
    chk("R7 release by pending non-owner", int'(err_count), exp_err);
    chk("R7 owner kept", int'(owner), 1);
    send_a(8'h15); exp_err++;
    chk("R2 bad opcode counted", int'(err_count), exp_err);
    send_a(8'h21); exp_err++;
    chk("R2 wrong identity counted", int'(err_count), exp_err);
    chk("R2 wrong identity no effect", int'(owner), 1);
    send_a(8'h13);
    chk("R7 pending kept after ignored release", int'(owner), 2);
    send2(1'b1, 8'h13, 1'b1, 8'h21);
    chk("R7 two ignored saturate", int'(err_count), 7);
    send_a(8'h00);
    chk("R7 saturation holds", int'(err_count), 7);
    send_b(8'h23);
    chk("R7 final release", int'(owner), 0);

    // R8 R9 R10 sweep over hold limit and kill length
    do_reset();
    for (int lim = 1; lim <= 6; lim++) begin
      for (int kl = 1; kl <= 4; kl++) begin
        hold_limit = TMR_W'(lim);
        kill_len = KILL_W'(kl);
        send_a(8'h11);
        chk("R8 sweep grant", int'(owner), 1);
        send_b(8'h21);
        cnt = 1;
        while (owner != 2'd0 && cnt < 40) begin
          step();
          cnt++;
        end
        chk($sformatf("R8 hold window lim=%0d", lim), cnt, lim);
        chk("R8 timeout strobe", int'(timeout_evt), 1);
        chk("R9 kill with strobe", int'(kill), 1);
        cnt = 0;
        while (kill && cnt < 20) begin
          chk("R9 ready low in kill", int'(a_cmd_ready | b_cmd_ready), 0);
          step();
          cnt++;
        end
        chk($sformatf("R9 kill width kl=%0d", kl), cnt, kl);
        chk("R9 no grant as kill falls", int'(owner), 0);
        step();
        chk("R9 pending grant after kill", int'(owner), 2);
        chk("R9 grant strobe after kill", int'(gnt_valid), 1);
        send_b(8'h23);
        chk("R8 release beats expiry", int'(owner), 0);
        chk("R8 no timeout on release", int'(timeout_evt), 0);
        chk("R8 no kill on release", int'(kill), 0);
        if (lim >= 2) begin
          send_a(8'h11);
          for (int s = 0; s < lim - 2; s++) step();
          send_a(8'h13);
          send_a(8'h11);
          for (int s = 0; s < lim - 1; s++) step();
          chk("R10 timer restarted on grant", int'(owner), 1);
          step();
          chk("R10 expiry after full window", int'(timeout_evt), 1);
          cnt = 0;
          while (kill && cnt < 20) begin
            step();
            cnt++;
          end
        end
        step();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule